// File: doc/BRIEF.md
# Landing Pad Instruction Checker

This block enforces forward-edge control-flow integrity at the retire point of an instruction stream. While the hart's expected-landing-pad state says a landing pad must come next, every valid instruction offered to the checker is examined. The instruction must be a full-width, word-aligned landing pad, and its label must either be zero or equal the expected label held in the upper field of the label register. A landing pad is recognised by the AUIPC major opcode with a zero destination register.

When the checks pass, the checker pulses a strobe that tells the surrounding pipeline to drop the expectation. When they fail, it pulses a fault carrying the software-check exception cause and the landing-pad fault code, and the pipeline must not retire that instruction. When enforcement is off, or no landing pad is expected, the checker stays silent and a landing pad is just a no-op. Setting the expectation after an indirect jump is done elsewhere.

All results are registered. They appear one clock after the instruction is presented, and each lasts exactly one cycle.

Top module: `lpad_checker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `fault_o` and `elp_clear_o` are 0, and `cause_o` and `tval_o` are 0.
- R2: An instruction is a landing pad only when bits [6:0] equal 7'b0010111 and bits [11:7] equal 5'b00000. Its label is bits [31:12]. An AUIPC with a nonzero destination register is not a landing pad.
- R3: When `valid_i`, `lp_en_i` or `lp_expected_i` is 0, neither `fault_o` nor `elp_clear_o` is raised in the following cycle, whatever the instruction.
- R4: While checking is active (`valid_i`, `lp_en_i` and `lp_expected_i` all 1), a PC with bits [1:0] other than 2'b00 faults, even for a valid landing pad.
- R5: While checking is active, a 32-bit instruction that is not a landing pad faults.
- R6: While checking is active, an instruction flagged compressed (`is_rvc_i` = 1) faults, even if its bits decode as a landing pad.
- R7: While checking is active, an aligned landing pad with a nonzero label that differs from `x7_i[31:12]` faults.
- R8: While checking is active, an aligned landing pad with label 0 passes whatever `x7_i` holds, and raises `elp_clear_o`.
- R9: While checking is active, an aligned landing pad whose label equals `x7_i[31:12]` raises `elp_clear_o`. Bits [11:0] of `x7_i` play no part in the comparison.
- R10: In a fault cycle, `cause_o` = 18 and `tval_o` = 2. In every other cycle, both are 0.
- R11: `fault_o` and `elp_clear_o` are never 1 together. Each is a one-cycle pulse issued on the clock edge after the instruction that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | An instruction is presented for checking this cycle |
| pc_i | input | XLEN (32) | Address of the presented instruction |
| instr_i | input | 32 | Instruction word (upper half ignored for decode when compressed) |
| is_rvc_i | input | 1 | Presented instruction is a 16-bit compressed one |
| lp_expected_i | input | 1 | Expected-landing-pad state: 1 = a landing pad must come next |
| lp_en_i | input | 1 | Landing-pad enforcement enabled for the current privilege |
| x7_i | input | XLEN (32) | Current value of the label register; bits [31:12] hold the expected label |
| fault_o | output | 1 | Landing-pad fault pulse; the instruction must not retire |
| cause_o | output | XLEN (32) | Exception cause, 18 during a fault, else 0 |
| tval_o | output | XLEN (32) | Trap value, 2 during a fault, else 0 |
| elp_clear_o | output | 1 | Pulse telling the pipeline to drop the landing-pad expectation |

## Verification
Every result of this block (the fault, its cause and tval, and the clear strobe) is due exactly one rising edge after the instruction is driven, and it must be gone on the edge after that. The bench drives inputs on the falling edge and drops `valid_i` on the next falling edge. It samples the outputs there, half a period after the edge that registered them. One falling edge later it samples again to confirm that both pulses have returned to zero. The gating, alignment, compressed, opcode and label cases each get their own task, so that each outcome is checked in its own cycle.

// File: rtl/lpad_checker_pkg.sv
package lpad_checker_pkg;

    localparam int unsigned ILEN       = 32;
    localparam int unsigned LBL_W      = 20;
    localparam int unsigned LBL_LSB    = 12;
    localparam logic [6:0]  OPC_AUIPC  = 7'b0010111;
    localparam int unsigned SWCHK_CAUSE = 18;
    localparam int unsigned LPAD_TVAL   = 2;

    typedef struct packed {
        logic fault;
        logic elp_clear;
    } lp_verdict_t;

endpackage

// File: rtl/lpad_decode.sv
module lpad_decode
    import lpad_checker_pkg::*;
(
    input  logic [ILEN-1:0]  insn_i,
    output logic             is_lpad_o,
    output logic [LBL_W-1:0] label_o
);
    localparam int unsigned RD_LSB = 7;
    localparam int unsigned RD_W   = 5;

    logic opc_hit;
    logic rd_zero;

    always_comb begin
        opc_hit   = (insn_i[RD_LSB-1:0] == OPC_AUIPC);
        rd_zero   = (insn_i[RD_LSB +: RD_W] == '0);
        is_lpad_o = opc_hit && rd_zero;
        label_o   = insn_i[LBL_LSB +: LBL_W];
    end
endmodule

// File: rtl/lpad_label_cmp.sv
module lpad_label_cmp #(
    parameter int unsigned W = 20
) (
    input  logic [W-1:0] insn_label_i,
    input  logic [W-1:0] exp_label_i,
    output logic         label_ok_o
);
    logic [W-1:0] bit_eq;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign bit_eq[b] = ~(insn_label_i[b] ^ exp_label_i[b]);
    end

    assign label_ok_o = (insn_label_i == '0) || (&bit_eq);
endmodule

// File: rtl/lpad_checker.sv
module lpad_checker
    import lpad_checker_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            valid_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [31:0]     instr_i,
    input  logic            is_rvc_i,
    input  logic            lp_expected_i,
    input  logic            lp_en_i,
    input  logic [XLEN-1:0] x7_i,
    output logic            fault_o,
    output logic [XLEN-1:0] cause_o,
    output logic [XLEN-1:0] tval_o,
    output logic            elp_clear_o
);
    localparam logic [XLEN-1:0] CAUSE_VAL = XLEN'(SWCHK_CAUSE);
    localparam logic [XLEN-1:0] TVAL_VAL  = XLEN'(LPAD_TVAL);

    typedef struct packed {
        lp_verdict_t     v;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
    } lp_out_t;

    logic             is_lpad;
    logic [LBL_W-1:0] insn_label;
    logic             label_ok;
    lp_out_t          out_d, out_q;

    lpad_decode u_decode (
        .insn_i    (instr_i),
        .is_lpad_o (is_lpad),
        .label_o   (insn_label)
    );

    lpad_label_cmp #(.W(LBL_W)) u_cmp (
        .insn_label_i (insn_label),
        .exp_label_i  (x7_i[LBL_LSB +: LBL_W]),
        .label_ok_o   (label_ok)
    );

    always_comb begin
        logic active;
        logic shape_ok;
        active   = valid_i && lp_en_i && lp_expected_i;
        shape_ok = !is_rvc_i && (pc_i[1:0] == 2'b00) && is_lpad;
        out_d    = '0;
        if (active) begin
            if (shape_ok && label_ok) begin
                out_d.v.elp_clear = 1'b1;
            end else begin
                out_d.v.fault = 1'b1;
                out_d.cause   = CAUSE_VAL;
                out_d.tval    = TVAL_VAL;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign fault_o     = out_q.v.fault;
    assign elp_clear_o = out_q.v.elp_clear;
    assign cause_o     = out_q.cause;
    assign tval_o      = out_q.tval;
endmodule

// File: rtl/lpad_checker_sva.sv
module lpad_checker_sva #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            valid_i,
    input logic [XLEN-1:0] pc_i,
    input logic            is_rvc_i,
    input logic            lp_expected_i,
    input logic            lp_en_i,
    input logic            fault_o,
    input logic [XLEN-1:0] cause_o,
    input logic [XLEN-1:0] tval_o,
    input logic            elp_clear_o
);
    logic act;
    assign act = valid_i && lp_en_i && lp_expected_i;

    // R11
    excl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(fault_o && elp_clear_o));

    // R10
    fault_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> (cause_o == XLEN'(18)) && (tval_o == XLEN'(2)));

    // R10
    idle_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fault_o |-> (cause_o == '0) && (tval_o == '0));

    // R3
    gated_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !act |=> !fault_o && !elp_clear_o);

    // R6
    rvc_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act && is_rvc_i) |=> fault_o);

    // R4
    misalign_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act && pc_i[1:0] != 2'b00) |=> fault_o);
endmodule

bind lpad_checker lpad_checker_sva #(.XLEN(XLEN)) u_sva (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (valid_i),
    .pc_i          (pc_i),
    .is_rvc_i      (is_rvc_i),
    .lp_expected_i (lp_expected_i),
    .lp_en_i       (lp_en_i),
    .fault_o       (fault_o),
    .cause_o       (cause_o),
    .tval_o        (tval_o),
    .elp_clear_o   (elp_clear_o)
);

// File: tb/test_lpad_checker.sv
module test_lpad_checker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid;
    logic [31:0] pc;
    logic [31:0] instr;
    logic        rvc;
    logic        expd;
    logic        en;
    logic [31:0] x7;
    logic        fault;
    logic [31:0] cause;
    logic [31:0] tval;
    logic        clr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpad_checker i_lpad_checker (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pc_i(pc),
        .instr_i(instr), .is_rvc_i(rvc), .lp_expected_i(expd),
        .lp_en_i(en), .x7_i(x7), .fault_o(fault), .cause_o(cause),
        .tval_o(tval), .elp_clear_o(clr)
    );

    function automatic logic [31:0] lpad(input logic [19:0] lbl);
        return {lbl, 5'b00000, 7'b0010111};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one instruction, then check the registered verdict and its release.
    task automatic present(input string req, input logic [31:0] p, input logic [31:0] ins,
                           input logic c, input logic e, input logic n, input logic [31:0] r7,
                           input logic exp_fault, input logic exp_clr);
        @(negedge clk);
        valid = 1'b1; pc = p; instr = ins; rvc = c; expd = e; en = n; x7 = r7;
        @(negedge clk);
        valid = 1'b0;
        chk({req, " fault"}, {31'b0, fault}, {31'b0, exp_fault});
        chk({req, " clear"}, {31'b0, clr}, {31'b0, exp_clr});
        chk({req, " cause"}, cause, exp_fault ? 32'd18 : 32'd0);
        chk({req, " tval"}, tval, exp_fault ? 32'd2 : 32'd0);
        @(negedge clk);
        chk({req, " pulse end"}, {30'b0, fault, clr}, 32'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; valid = 1'b1; pc = 32'h2; instr = 32'h0; rvc = 1'b1;
        expd = 1'b1; en = 1'b1; x7 = 32'h0;
        repeat (3) @(negedge clk);
        chk("R1 fault in reset", {31'b0, fault}, 32'd0);
        chk("R1 clear in reset", {31'b0, clr}, 32'd0);
        chk("R1 cause in reset", cause, 32'd0);
        valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {30'b0, fault, clr}, 32'd0);
        chk("R1 tval after reset", tval, 32'd0);
    endtask

    task automatic t_gating;
        present("R3 disabled bad insn", 32'h1002, 32'h00000013, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0);
        present("R3 not expected", 32'h1000, 32'h00000013, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0);
        present("R3 lpad no-op", 32'h1000, lpad(20'h5), 1'b0, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        valid = 1'b0; pc = 32'h3; instr = 32'h13; rvc = 1'b1; expd = 1'b1; en = 1'b1;
        @(negedge clk);
        chk("R3 invalid slot", {30'b0, fault, clr}, 32'd0);
    endtask

    task automatic t_align;
        present("R4 pc+2", 32'h1002, lpad(20'h0), 1'b0, 1'b1, 1'b1, 32'h0, 1'b1, 1'b0);
        present("R4 pc+1", 32'h1001, lpad(20'h0), 1'b0, 1'b1, 1'b1, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_not_lpad;
        present("R5 addi", 32'h1000, 32'h00000013, 1'b0, 1'b1, 1'b1, 32'h0, 1'b1, 1'b0);
        present("R2 R5 auipc x5", 32'h1000, {20'h0, 5'd5, 7'b0010111}, 1'b0, 1'b1, 1'b1, 32'h0, 1'b1, 1'b0);
        present("R2 R5 lui x0", 32'h1000, {20'h0, 5'd0, 7'b0110111}, 1'b0, 1'b1, 1'b1, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_rvc;
        present("R6 compressed lpad bits", 32'h1000, lpad(20'h0), 1'b1, 1'b1, 1'b1, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_labels;
        present("R7 mismatch", 32'h2000, lpad(20'h00ABC), 1'b0, 1'b1, 1'b1, 32'h00ABD000, 1'b1, 1'b0);
        present("R7 x7 zero", 32'h2000, lpad(20'h80000), 1'b0, 1'b1, 1'b1, 32'h00000FFF, 1'b1, 1'b0);
        present("R8 wildcard", 32'h2000, lpad(20'h0), 1'b0, 1'b1, 1'b1, 32'hDEADBEEF, 1'b0, 1'b1);
        present("R9 R2 match", 32'h2000, lpad(20'hFEDCB), 1'b0, 1'b1, 1'b1, 32'hFEDCB000, 1'b0, 1'b1);
        present("R9 low bits ignored", 32'h2004, lpad(20'h12345), 1'b0, 1'b1, 1'b1, 32'h12345FFF, 1'b0, 1'b1);
    endtask

    task automatic t_back_to_back;
        // R11: a clear followed at once by a fault, each one cycle wide
        @(negedge clk);
        valid = 1'b1; pc = 32'h3000; instr = lpad(20'h0); rvc = 1'b0; expd = 1'b1; en = 1'b1; x7 = 32'h0;
        @(negedge clk);
        chk("R11 first clear", {30'b0, fault, clr}, 32'd1);
        instr = 32'h00000013;
        @(negedge clk);
        valid = 1'b0;
        chk("R11 then fault", {30'b0, fault, clr}, 32'd2);
        chk("R10 cause b2b", cause, 32'd18);
        @(negedge clk);
        chk("R11 release", {30'b0, fault, clr}, 32'd0);
    endtask

    initial begin
        fork
            begin
                #(CLK_PERIOD * 2000);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
            begin
                t_reset();
                t_gating();
                t_align();
                t_not_lpad();
                t_rvc();
                t_labels();
                t_back_to_back();
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule